// File: doc/BRIEF.md
# Event Counter with Switchable Prescaler

This block is a small timer/counter for a microcontroller-style core. An 8-bit counter advances on one of two sources. The first is a per-cycle enable from the instruction sequencer. The second is a chosen edge, rising or falling, on an external pin, which is synchronised to the clock inside the block.

A single power-of-two prescaler can sit in front of the counter. Software can instead hand that prescaler over to the watchdog. The watchdog then receives a divided tick, and the counter advances once per source event.

Software writes the mode byte and loads the count through a simple write strobe, and reads the count directly. A one-cycle overflow pulse marks each wrap from the top value back to zero. There are two reset inputs:
- A power-on reset clears everything.
- A warm reset, standing for a master-clear or watchdog reset, restores the mode to its default and leaves the count alone.

Top module: `rtc_timer`

## Requirements
- R1: After power-on reset the count reads 00h and the overflow output is low. The mode then selects the pin as source, falling edge, prescaler on the watchdog and ratio code 7. In that state `cyc_en` pulses do not count, a falling pin edge adds exactly one, and `wdt_tick` fires on the 128th `wdt_raw` event and not before.
- R2: A count write (`cnt_wr`) makes `count` equal `wdata` on the following cycle. It takes priority over an increment in the same cycle, and it resets the prescaler's internal event count to zero.
- R3: Mode byte layout:
  - bit 5: source select, 0 = `cyc_en`, 1 = pin
  - bit 4: pin edge select
  - bit 3: prescaler to the watchdog
  - bits 2..0: ratio code
  - bits 7..6: ignored

  With bit 3 set and bit 5 clear, the count rises by one for each cycle in which `cyc_en` is high, whatever the ratio code.
- R4: With bit 3 clear, the counter advances once per 2^(code+1) source events, counted from the last prescaler clear. This covers 1:2 for code 0 up to 1:256 for code 7.
- R5: With bit 3 set, `wdt_tick` pulses once per 2^code `wdt_raw` events. With bit 3 clear, `wdt_tick` stays low.
- R6: With bit 5 set and bit 4 clear, each rising pin edge counts, and falling edges do not. The count changes on the third rising clock edge after the pin changes.
- R7: With bit 5 set and bit 4 set, each falling pin edge counts and rising edges do not. Pin events also pass through the prescaler when bit 3 is clear.
- R8: `ovf` is high for exactly one cycle, the cycle in which `count` first reads 00h after an increment from FFh. A write of 00h does not raise it.
- R9: The warm reset (`rst_n` low) leaves the count unchanged and returns the mode to its default of 3Fh.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous; clears the count |
| rst_n | input | 1 | Warm reset, active low, asynchronous; count retained |
| cyc_en | input | 1 | Instruction-cycle enable, internal count source |
| ext_pin | input | 1 | Asynchronous external count pin |
| wdt_raw | input | 1 | Raw watchdog time base event |
| cnt_wr | input | 1 | Write strobe for the count |
| mode_wr | input | 1 | Write strobe for the mode byte |
| wdata | input | 8 | Write data for count or mode |
| count | output | 8 | Current count |
| ovf | output | 1 | One-cycle wrap pulse |
| wdt_tick | output | 1 | Divided watchdog tick (combinational) |

## Verification
The timing of each result is as follows:
- **Count writes and `cyc_en` increments:** these take effect at the next rising edge. The bench drives them on a falling edge and reads `count` on the following falling edge.
- **Pin edges:** these pass two synchroniser stages and one edge register before the counter. The bench therefore reads `count` on the second falling edge after a pin change to confirm nothing has moved yet, and on the third to see the increment.
- **`ovf`:** this is registered alongside the count, so the bench reads it in the same half-cycle as the zero count, and again one cycle later to confirm it has dropped.
- **`wdt_tick`:** this is combinational from `wdt_raw` and the prescaler state. The bench reads it 5 ns after driving `wdt_raw`, before the rising edge that moves the prescaler.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
   localparam int RATIO_W = 3;

   typedef struct packed {
      logic               src_ext;
      logic               edge_fall;
      logic               pre_wdt;
      logic [RATIO_W-1:0] ratio;
   } rtc_mode_t;

   localparam rtc_mode_t MODE_DEFAULT = '{src_ext: 1'b1, edge_fall: 1'b1,
                                          pre_wdt: 1'b1, ratio: '1};
endpackage

// File: rtl/rtc_pin_sync.sv
module rtc_pin_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin,
   input  logic fall_sel,
   output logic evt
);
   logic [STAGES-1:0] sync_q;
   logic              last_q;

   if (STAGES < 2) begin : g_bad_stages
      $error("rtc_pin_sync: STAGES must be at least 2");
   end

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      logic d;
      if (i == 0) begin : g_first
         assign d = pin;
      end else begin : g_next
         assign d = sync_q[i-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sync_q[i] <= 1'b0;
         else        sync_q[i] <= d;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) last_q <= 1'b0;
      else        last_q <= sync_q[STAGES-1];
   end

   assign evt = fall_sel ? (last_q & ~sync_q[STAGES-1])
                         : (sync_q[STAGES-1] & ~last_q);

   AST_EDGE_ISOLATED: assert property (@(posedge clk) disable iff (!rst_n)
      evt |=> !evt); // R6
endmodule

// File: rtl/rtc_prescaler.sv
module rtc_prescaler
   import rtc_pkg::*;
(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clr,
   input  logic               ev_in,
   input  logic [RATIO_W-1:0] ratio,
   input  logic               to_wdt,
   output logic               tick
);
   localparam int PS_W = 2 ** RATIO_W;

   logic [PS_W-1:0]  pcnt_q;
   logic [PS_W-1:0]  mask;
   logic [RATIO_W:0] lg;

   // the watchdog table sits one power of two below the counter table
   assign lg = to_wdt ? {1'b0, ratio} : ({1'b0, ratio} + (RATIO_W+1)'(1));

   always_comb begin
      for (int i = 0; i < PS_W; i++) mask[i] = (i < int'(lg));
   end

   assign tick = ev_in && ((pcnt_q & mask) == mask);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     pcnt_q <= '0;
      else if (clr)   pcnt_q <= '0;
      else if (ev_in) pcnt_q <= pcnt_q + PS_W'(1);
   end

   AST_PRE_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (pcnt_q == '0)); // R2
   AST_PRE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && !ev_in) |=> $stable(pcnt_q)); // R4
endmodule

// File: rtl/rtc_counter.sv
module rtc_counter #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             por_n,
   input  logic             wr,
   input  logic [CNT_W-1:0] wdata,
   input  logic             inc,
   output logic [CNT_W-1:0] cnt,
   output logic             ovf
);
   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         cnt <= '0;
         ovf <= 1'b0;
      end else begin
         ovf <= 1'b0;
         if (wr) begin
            cnt <= wdata;
         end else if (inc) begin
            cnt <= cnt + CNT_W'(1);
            ovf <= &cnt;
         end
      end
   end

   AST_OVF_AT_ZERO: assert property (@(posedge clk) disable iff (!por_n)
      ovf |-> (cnt == '0)); // R8
   AST_OVF_SINGLE: assert property (@(posedge clk) disable iff (!por_n)
      ovf |=> !ovf); // R8
   AST_WRITE_LOADS: assert property (@(posedge clk) disable iff (!por_n)
      wr |=> (cnt == $past(wdata))); // R2
   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!por_n)
      (!wr && !inc) |=> $stable(cnt)); // R9
endmodule

// File: rtl/rtc_timer.sv
module rtc_timer
   import rtc_pkg::*;
#(
   parameter int CNT_W       = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             por_n,
   input  logic             rst_n,
   input  logic             cyc_en,
   input  logic             ext_pin,
   input  logic             wdt_raw,
   input  logic             cnt_wr,
   input  logic             mode_wr,
   input  logic [CNT_W-1:0] wdata,
   output logic [CNT_W-1:0] count,
   output logic             ovf,
   output logic             wdt_tick
);
   localparam int MODE_W = $bits(rtc_mode_t);

   if (CNT_W < MODE_W) begin : g_bad_width
      $error("rtc_timer: CNT_W must hold the mode byte fields");
   end

   logic      any_rst_n;
   rtc_mode_t mode_q;
   logic      pin_evt, src_evt, pre_in, pre_tick, cnt_inc;

   assign any_rst_n = por_n & rst_n;

   always_ff @(posedge clk or negedge any_rst_n) begin
      if (!any_rst_n)   mode_q <= MODE_DEFAULT;
      else if (mode_wr) mode_q <= rtc_mode_t'(wdata[MODE_W-1:0]);
   end

   rtc_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (any_rst_n),
      .pin      (ext_pin),
      .fall_sel (mode_q.edge_fall),
      .evt      (pin_evt)
   );

   assign src_evt = mode_q.src_ext ? pin_evt : cyc_en;
   assign pre_in  = mode_q.pre_wdt ? wdt_raw : src_evt;

   rtc_prescaler u_pre (
      .clk    (clk),
      .rst_n  (any_rst_n),
      .clr    (cnt_wr),
      .ev_in  (pre_in),
      .ratio  (mode_q.ratio),
      .to_wdt (mode_q.pre_wdt),
      .tick   (pre_tick)
   );

   assign cnt_inc  = mode_q.pre_wdt ? src_evt : pre_tick;
   assign wdt_tick = mode_q.pre_wdt & pre_tick;

   rtc_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk   (clk),
      .por_n (por_n),
      .wr    (cnt_wr),
      .wdata (wdata),
      .inc   (cnt_inc),
      .cnt   (count),
      .ovf   (ovf)
   );

   AST_WDT_TICK_NEEDS_RAW: assert property (@(posedge clk) disable iff (!any_rst_n)
      wdt_tick |-> wdt_raw); // R5
endmodule

// File: tb/tb_rtc_timer.sv
`timescale 1ns/1ps
module tb_rtc_timer;
   logic       clk = 1'b0;
   logic       por_n = 1'b0, rst_n = 1'b0;
   logic       cyc_en = 1'b0, ext_pin = 1'b0, wdt_raw = 1'b0;
   logic       cnt_wr = 1'b0, mode_wr = 1'b0;
   logic [7:0] wdata = 8'h00;
   logic [7:0] count;
   logic       ovf, wdt_tick;

   int checks = 0, fails = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   rtc_timer dut (
      .clk(clk), .por_n(por_n), .rst_n(rst_n), .cyc_en(cyc_en),
      .ext_pin(ext_pin), .wdt_raw(wdt_raw), .cnt_wr(cnt_wr),
      .mode_wr(mode_wr), .wdata(wdata), .count(count), .ovf(ovf),
      .wdt_tick(wdt_tick)
   );

   // {req[3:0], mode[7:0], start[7:0], events[11:0], expect[7:0]}
   localparam logic [39:0] VEC [9] = '{
      {4'd3, 8'h08, 8'h10, 12'd5,   8'h15},
      {4'd3, 8'hC8, 8'h40, 12'd3,   8'h43},
      {4'd3, 8'h0F, 8'hF0, 12'd16,  8'h00},
      {4'd4, 8'h00, 8'h00, 12'd7,   8'h03},
      {4'd4, 8'h02, 8'h20, 12'd20,  8'h22},
      {4'd4, 8'h03, 8'h80, 12'd48,  8'h83},
      {4'd4, 8'h04, 8'h10, 12'd100, 8'h13},
      {4'd4, 8'h05, 8'hFE, 12'd130, 8'h00},
      {4'd4, 8'h07, 8'h00, 12'd600, 8'h02}
   };

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic wr_mode(input logic [7:0] v);
      @(negedge clk); mode_wr = 1'b1; wdata = v;
      @(negedge clk); mode_wr = 1'b0;
   endtask

   task automatic wr_cnt(input logic [7:0] v);
      @(negedge clk); cnt_wr = 1'b1; wdata = v;
      @(negedge clk); cnt_wr = 1'b0;
   endtask

   task automatic pulse_cyc(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); cyc_en = 1'b1;
      end
      @(negedge clk); cyc_en = 1'b0;
   endtask

   task automatic raw_events(input int n, output int ticks);
      ticks = 0;
      for (int i = 0; i < n; i++) begin
         @(negedge clk); wdt_raw = 1'b1;
         #5 if (wdt_tick) ticks++;
      end
      @(negedge clk); wdt_raw = 1'b0;
   endtask

   task automatic set_pin(input logic v);
      @(negedge clk); ext_pin = v;
      repeat (3) @(negedge clk);
   endtask

   initial begin
      #(200000 * 20);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog: actual running expected finished");
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end

   initial begin
      int t;
      logic [7:0] c0;
      repeat (3) @(negedge clk);
      por_n = 1'b1; rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state and default mode
      chk("R1 count", count, 8'h00);
      chk("R1 ovf", ovf, 0);
      pulse_cyc(4);
      chk("R1 cyc_en ignored", count, 8'h00);
      set_pin(1'b1);
      chk("R1 rising ignored", count, 8'h00);
      set_pin(1'b0);
      chk("R1 falling counts", count, 8'h01);
      raw_events(127, t);
      chk("R1 wdt no early tick", t, 0);
      raw_events(1, t);
      chk("R1 wdt tick at 128", t, 1);

      // R3 R4 table walk
      foreach (VEC[k]) begin
         wr_mode(VEC[k][35:28]);
         wr_cnt(VEC[k][27:20]);
         pulse_cyc(int'(VEC[k][19:8]));
         chk((VEC[k][39:36] == 4'd3) ? "R3 vector" : "R4 vector",
             count, VEC[k][7:0]);
      end

      // R2: write priority, readback, prescaler clear
      wr_mode(8'h08);
      @(negedge clk); cnt_wr = 1'b1; cyc_en = 1'b1; wdata = 8'h55;
      @(negedge clk); cnt_wr = 1'b0; cyc_en = 1'b0;
      chk("R2 write wins", count, 8'h55);
      wr_mode(8'h01);
      wr_cnt(8'h00);
      pulse_cyc(3);
      wr_cnt(8'h00);
      pulse_cyc(1);
      chk("R2 prescaler cleared", count, 8'h00);

      // R5: watchdog ratio
      wr_mode(8'h0A);
      wr_cnt(8'h00);
      raw_events(16, t);
      chk("R5 wdt 1:4", t, 4);
      wr_mode(8'h08);
      raw_events(5, t);
      chk("R5 wdt 1:1", t, 5);
      wr_mode(8'h00);
      raw_events(16, t);
      chk("R5 wdt quiet", t, 0);
      chk("R5 count untouched", count, 8'h00);

      // R6: rising edge with latency
      wr_mode(8'h28);
      wr_cnt(8'h10);
      @(negedge clk); ext_pin = 1'b1;
      repeat (2) @(negedge clk);
      chk("R6 not before third edge", count, 8'h10);
      @(negedge clk);
      chk("R6 rising counts", count, 8'h11);
      set_pin(1'b0);
      chk("R6 falling ignored", count, 8'h11);

      // R7: falling edge, through the prescaler 1:2
      wr_mode(8'h30);
      wr_cnt(8'h00);
      for (int i = 0; i < 4; i++) begin
         set_pin(1'b1);
         set_pin(1'b0);
      end
      chk("R7 falling via 1:2", count, 8'h02);

      // R8: overflow pulse
      wr_mode(8'h08);
      wr_cnt(8'hFF);
      pulse_cyc(1);
      chk("R8 wrap count", count, 8'h00);
      chk("R8 ovf high", ovf, 1);
      @(negedge clk);
      chk("R8 ovf one cycle", ovf, 0);
      wr_cnt(8'hFF);
      wr_cnt(8'h00);
      chk("R8 write no ovf", ovf, 0);

      // R9: warm reset keeps count, restores mode
      wr_cnt(8'h77);
      @(negedge clk); rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R9 count kept", count, 8'h77);
      c0 = count;
      pulse_cyc(3);
      chk("R9 mode default", count, c0);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end
endmodule